// File: doc/BRIEF.md
# Three-wire serial EEPROM word reader

This block fetches 16-bit words from a small serial configuration EEPROM over a three-wire link. It drives the select, the shift clock and the data line into the memory, and it samples the memory's data line. Each request names a word and the address width to use. The controller first raises select. It then sends a start-plus-read opcode and the address, and clocks in sixteen data bits. It hands the word back with a single-cycle done pulse.

Parts of this kind come with either 6 or 8 address bits. A probe request reads word 0 with 8-bit addressing. The result is kept in a width flag: the flag is set when the word equals the signature 0x8129 and cleared otherwise. Later requests that set `req_auto` use the width held in the flag rather than the width they carry. Write and erase commands are not supported.

Top module: `sprom_reader`

## Requirements
- R1: During and straight after reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `wide_det` are all 0.
- R2: The command is shifted out most significant bit first on `ee_di`. It is the three bits 1,1,0 (leading start bit, then read opcode 10) followed by the address. The address has 8 bits when the chosen width is wide (`req_wide`=1) and is the low 6 bits of `req_addr` when it is narrow, so 3+width bits are sent in total.
- R3: Each command bit occupies two slots of HALF clock cycles. In the first slot `ee_sk` is low with the bit on `ee_di`; in the second slot `ee_sk` is high with `ee_di` unchanged. `ee_sk` is never high while `ee_cs` is low.
- R4: After the last command bit there is one slot with `ee_sk` low and `ee_di` low. Then come 16 clock pulses, each one high slot and one low slot. `ee_do` is sampled at the end of each high slot, and the first sample is bit 15 of the returned word. `ee_di` stays low during this phase.
- R5: `ee_cs` rises in the cycle after an accepted request. The first slot holds `ee_sk` and `ee_di` low. `ee_cs` then stays high through the final low slot and is low in the cycle in which `done` is high.
- R6: `done` is high for exactly one cycle when a read completes, and `rdata` carries the word in that cycle. `rdata` holds that value until the next completion.
- R7: A request raised while `busy` is high is ignored, and the transfer in progress runs to completion unchanged. A request held high through the `done` cycle is accepted on the following edge.
- R8: A probe request (`req_probe`=1) reads word 0 with 8-bit addressing. In its `done` cycle `wide_det` becomes 1 if the word read equals 0x8129 and becomes 0 otherwise.
- R9: With `req_auto`=1 and `req_probe`=0, the address width is taken from `wide_det` (1 means 8 bits, 0 means 6 bits) and `req_wide` is ignored.
- R10: `req_probe` takes precedence: when it is 1, `req_addr`, `req_wide` and `req_auto` have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a read; taken only while idle |
| req_addr | input | 8 | Word address (low 6 bits used for narrow width) |
| req_wide | input | 1 | 1 selects 8 address bits, 0 selects 6 |
| req_auto | input | 1 | Use the detected width flag instead of `req_wide` |
| req_probe | input | 1 | Read word 0 wide and update the width flag |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Word returned by the last completed read |
| wide_det | output | 1 | Detected address width, 1 for 8 bits |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the controller with a half-period of 3 system clocks rather than the default of 4. An odd slot length shows that every slot takes exactly HALF cycles. The same tests run against a modelled memory configured first as an 8-bit part and then as a 6-bit part. Both the matching-width reads and the probe outcomes (signature present or absent) are therefore reached. This setup also covers narrow and wide command lengths, auto width before and after a probe, and a request held through the completion cycle.

// File: rtl/sprom_reader.sv
module sprom_reader #(
  parameter int HALF      = 4,
  parameter int DW        = 16,
  parameter int AW_WIDE   = 8,
  parameter int AW_NARROW = 6,
  parameter logic [15:0] SIGNATURE = 16'h8129
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW_WIDE-1:0] req_addr,
  input  logic          req_wide,
  input  logic          req_auto,
  input  logic          req_probe,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          wide_det,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  input  logic          ee_do
);
  localparam int CMDW = 3 + AW_WIDE;
  localparam int CW   = $clog2(HALF + 1);
  localparam int IW   = $clog2(CMDW + DW);
  localparam logic [IW-1:0] LAST_WIDE   = IW'(CMDW - 1);
  localparam logic [IW-1:0] LAST_NARROW = IW'(3 + AW_NARROW - 1);
  localparam logic [IW-1:0] LAST_DATA   = IW'(DW - 1);
  localparam logic [CW-1:0] CNT_TOP     = CW'(HALF - 1);

  typedef enum logic [2:0] {IDLE, SEL, CMD_LO, CMD_HI, GAP, DAT_HI, DAT_LO} st_t;

  st_t             state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic [CMDW-1:0] cmd;
  logic [DW-1:0]   shreg;
  logic            wide_q, probe_q;
  logic            use_wide;

  assign use_wide = req_probe | (req_auto ? wide_det : req_wide);

  assign busy  = (state != IDLE);
  assign ee_cs = busy;
  assign ee_sk = (state == CMD_HI) || (state == DAT_HI);
  assign ee_di = ((state == CMD_LO) || (state == CMD_HI)) && cmd[CMDW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      idx      <= '0;
      cmd      <= '0;
      shreg    <= '0;
      wide_q   <= 1'b0;
      probe_q  <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      wide_det <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == IDLE) begin
        if (req) begin
          wide_q  <= use_wide;
          probe_q <= req_probe;
          if (req_probe)
            cmd <= {3'b110, {AW_WIDE{1'b0}}};
          else if (use_wide)
            cmd <= {3'b110, req_addr};
          else
            cmd <= {3'b110, req_addr[AW_NARROW-1:0], {(AW_WIDE-AW_NARROW){1'b0}}};
          cnt   <= CNT_TOP;
          state <= SEL;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= CNT_TOP;
        case (state)
          SEL: begin
            idx   <= '0;
            state <= CMD_LO;
          end
          CMD_LO: state <= CMD_HI;
          CMD_HI: begin
            cmd <= {cmd[CMDW-2:0], 1'b0};
            if (idx == (wide_q ? LAST_WIDE : LAST_NARROW)) begin
              state <= GAP;
            end else begin
              idx   <= idx + 1'b1;
              state <= CMD_LO;
            end
          end
          GAP: begin
            idx   <= '0;
            state <= DAT_HI;
          end
          DAT_HI: begin
            shreg <= {shreg[DW-2:0], ee_do};
            state <= DAT_LO;
          end
          DAT_LO: begin
            if (idx == LAST_DATA) begin
              state <= IDLE;
              done  <= 1'b1;
              rdata <= shreg;
              if (probe_q) wide_det <= (shreg == SIGNATURE);
            end else begin
              idx   <= idx + 1'b1;
              state <= DAT_HI;
            end
          end
          default: state <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sprom_reader_chk.sv
module sprom_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_cs_dropped_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_cs && !busy));

  a_r5_select_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (!ee_sk && !ee_di));

  a_r3_di_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_di));

  a_r3_sk_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
endmodule

bind sprom_reader sprom_reader_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .ee_cs (ee_cs),
  .ee_sk (ee_sk),
  .ee_di (ee_di)
);

// File: tb/sprom_reader_test.sv
module sprom_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [7:0] req_addr = '0;
  logic req_wide = 1'b0, req_auto = 1'b0, req_probe = 1'b0;
  logic busy, done, wide_det, ee_cs, ee_sk, ee_di;
  logic [15:0] rdata;
  logic ee_do = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;
  int chip_abits = 8;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprom_reader #(.HALF(HALF_T)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .req_wide(req_wide), .req_auto(req_auto), .req_probe(req_probe),
    .busy(busy), .done(done), .rdata(rdata), .wide_det(wide_det),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] mem_word(int a, int cw);
    logic [7:0] b = 8'(a);
    if (a == 0) return (cw == 8) ? 16'h8129 : 16'h8128;
    return {b ^ 8'h5A, ~b};
  endfunction

  // behavioural EEPROM
  bit ms_started = 0, ms_data = 0;
  int ms_nb = 0, ms_k = 0, ms_adr = 0;
  logic [1:0] ms_opc = '0;
  logic [15:0] ms_word = '0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      ms_started = 0; ms_data = 0; ms_nb = 0; ms_k = 0; ms_adr = 0; ee_do = 1'b0;
    end else if (ms_data) begin
      ee_do = (ms_k < 16) ? ms_word[15-ms_k] : 1'b0;
      ms_k++;
    end else if (!ms_started) begin
      if (ee_di) begin ms_started = 1; ms_nb = 0; ms_opc = '0; ms_adr = 0; end
    end else begin
      if (ms_nb < 2) ms_opc = {ms_opc[0], ee_di};
      else ms_adr = (ms_adr << 1) | int'(ee_di);
      ms_nb++;
      if (ms_nb == 2 + chip_abits) begin
        ms_data = 1; ms_k = 0;
        ms_word = (ms_opc == 2'b10) ? mem_word(ms_adr, chip_abits) : 16'h0000;
      end
    end
  end

  // reference model: expected {cs,sk,di,done} per cycle
  logic [3:0] q[$];
  bit m_wide = 0;
  bit pend_known = 0, pend_probe = 0, pend_newwide = 0;
  logic [15:0] pend_data = '0;
  bit last_known = 0;
  logic [15:0] last_data = '0;

  task automatic push_slot(logic [3:0] v);
    for (int i = 0; i < HALF_T; i++) q.push_back(v);
  endtask

  always @(posedge clk) begin
    if (rst_n && req && q.size() == 0) begin
      int aw;
      int a;
      logic [10:0] c;
      aw = req_probe ? 8 : (req_auto ? (m_wide ? 8 : 6) : (req_wide ? 8 : 6));
      a  = req_probe ? 0 : ((aw == 8) ? int'(req_addr) : int'(req_addr[5:0]));
      c  = (aw == 8) ? {3'b110, 8'(a)} : {3'b110, 6'(a), 2'b00};
      push_slot(4'b1000);
      for (int b = 0; b < 3 + aw; b++) begin
        push_slot({2'b10, c[10-b], 1'b0});
        push_slot({2'b11, c[10-b], 1'b0});
      end
      push_slot(4'b1000);
      for (int d = 0; d < 16; d++) begin
        push_slot(4'b1100);
        push_slot(4'b1000);
      end
      q.push_back(4'b0001);
      pend_known   = (aw == chip_abits);
      pend_data    = mem_word(a, chip_abits);
      pend_probe   = req_probe;
      pend_newwide = (chip_abits == 8);
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] e;
      e = (q.size() != 0) ? q.pop_front() : 4'b0000;
      chk("R5 ee_cs", 16'(ee_cs), 16'(e[3]));
      chk("R3 ee_sk", 16'(ee_sk), 16'(e[2]));
      chk("R2 ee_di", 16'(ee_di), 16'(e[1]));
      chk("R6 done",  16'(done),  16'(e[0]));
      chk("R7 busy",  16'(busy),  16'(e[3]));
      if (e[0]) begin
        if (pend_probe) m_wide = pend_newwide;
        last_known = pend_known;
        last_data  = pend_data;
        if (pend_known) chk("R4 rdata", rdata, pend_data);
      end else if (last_known) begin
        chk("R6 rdata held", rdata, last_data);
      end
      chk("R8 wide_det", 16'(wide_det), 16'(m_wide));
    end
  end

  task automatic issue(bit probe, bit aut, bit wide, logic [7:0] addr);
    @(negedge clk);
    req = 1'b1; req_probe = probe; req_auto = aut; req_wide = wide; req_addr = addr;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || busy);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {11'b0, ee_cs, ee_sk, ee_di, busy, done}, 16'h0000);
    chk("R1 reset wide_det", 16'(wide_det), 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {11'b0, ee_cs, ee_sk, ee_di, busy, wide_det}, 16'h0000);

    // 8-bit part: wide reads (R2, R4)
    chip_abits = 8;
    issue(0, 0, 1, 8'h35); wait_idle();
    issue(0, 0, 1, 8'hC7); wait_idle();
    // R7: request during a transfer is ignored
    issue(0, 0, 1, 8'h81);
    repeat (20) @(negedge clk);
    issue(0, 0, 0, 8'h12);
    wait_idle();

    // 6-bit part: narrow read uses low 6 address bits (R2)
    chip_abits = 6;
    issue(0, 0, 0, 8'hEA); wait_idle();
    // R8: probe on a part without the signature clears the flag
    issue(1, 0, 0, 8'h00); wait_idle();
    // R9: auto read picks the narrow width despite req_wide
    issue(0, 1, 1, 8'h17); wait_idle();

    // 8-bit part: auto before probe still narrow (R9)
    chip_abits = 8;
    issue(0, 1, 1, 8'h44); wait_idle();
    // R10: probe overrides address, width and auto; R8 sets flag
    issue(1, 1, 0, 8'h55); wait_idle();
    chk("R8 flag set after signature", 16'(wide_det), 16'h0001);
    // R9: auto now wide despite req_wide=0
    issue(0, 1, 0, 8'h9C); wait_idle();

    // R7: request held through done is taken on the next edge
    @(negedge clk);
    req = 1'b1; req_probe = 0; req_auto = 0; req_wide = 1; req_addr = 8'hF0;
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    wait_idle();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule